// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block is a 64-bit packed-integer arithmetic unit. Both operands are read as rows of independent subwords: eight bytes, four halfwords or two words, picked per operation. Every lane gets its own result. No carry, borrow or rounding bit ever leaks from one lane into the next. Four lane operations are offered: add, subtract, rounding average, and shift-then-add. The last one scales operand A by a power of two before adding B, which makes it a cheap multiply-by-constant step.

Add, subtract and shift-then-add each take an overflow policy. Wrap keeps the low bits. Signed saturation clamps to the lane's most positive or most negative two's-complement value. Unsigned saturation clamps to all-ones on overflow and to zero on underflow. The average keeps the carry out in an extra internal bit, so it can never overflow and is never clamped.

One byte-sliced adder serves all lane sizes. The lane size selects where the carry chain is cut. The result and a valid flag are registered, so a request presented with its strobe shows up on the outputs one clock later.

Top module: `simd_sat_alu`

## Requirements
- R1: Lane size select 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane n occupies bits [n*W+W-1 : n*W] of every operand and of the result. No carry or borrow crosses a lane boundary.
- R2: Operation select is encoded as 0 add, 1 subtract, 2 average, 3 shift-then-add. Policy select is encoded as 0 or 3 wrap, 1 signed saturate, 2 unsigned saturate. With wrap, add returns (a+b) mod 2^W in each lane.
- R3: With signed saturation, add, subtract and shift-then-add clamp a lane that overflows positively to 2^(W-1)-1 and one that overflows negatively to -2^(W-1) (0x7FFF and 0x8000 for 16-bit lanes).
- R4: With unsigned saturation, a lane sum above 2^W-1 becomes all-ones and a lane difference below zero becomes 0. For example, adding 20 to 0 gives 20, subtracting 20 from 0 gives 0, and adding those two results gives 20, not 0.
- R5: Subtract returns a-b per lane, wrapping when the policy is wrap.
- R6: Average returns floor((a+b+1)/2) per lane. Lanes are read as signed under signed saturation and as unsigned under any other policy. The result is never clamped.
- R7: Shift-then-add uses shift field bits [1:0] as the amount k (0 to 3) and bit 2 as the direction (0 left, 1 right). A left shift drops bits beyond the lane. A right shift is arithmetic under signed saturation and logical otherwise. The shifted A is then added to B under the selected policy.
- R8: Output valid equals the input strobe of the previous cycle. The result register loads only on a strobed cycle and holds its value otherwise.
- R9: While reset is asserted, the output valid and result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | Packed operand A |
| opnd_b | input | 64 | Packed operand B |
| lane_sel | input | 2 | Lane size select |
| op_sel | input | 2 | Lane operation select |
| sat_sel | input | 2 | Overflow policy select |
| shift_sel | input | 3 | Shift-then-add amount and direction |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Packed registered result |

## Verification
Every result, and its valid flag, is due exactly one clock edge after the edge that captures the strobed request. There is no other latency. The bench drives each request on a falling edge and samples on the next falling edge, after one rising edge has gone by, and compares against per-lane integer arithmetic. After each configuration it presents one unstrobed cycle with altered operands. On the following falling edge it confirms that the valid flag has dropped and that the result has held.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        LANE_8   = 2'd0,
        LANE_16  = 2'd1,
        LANE_32  = 2'd2,
        LANE_32B = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_AVG   = 2'd2,
        OP_SHADD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        POL_WRAP  = 2'd0,
        POL_SSAT  = 2'd1,
        POL_USAT  = 2'd2,
        POL_WRAPB = 2'd3
    } pol_e;

    // number of selectable lane sizes: 8 << g for g in 0..LANE_KINDS-1
    localparam int LANE_KINDS = 3;

endpackage

// File: rtl/simd_preshift.sv
module simd_preshift
    import simd_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  lane_e         lane,
    input  logic [2:0]    shift,
    input  logic          arith,
    output logic [DW-1:0] a_shifted
);
    logic [DW-1:0] cand [LANE_KINDS];

    for (genvar g = 0; g < LANE_KINDS; g++) begin : g_size
        localparam int W = 8 << g;
        localparam int N = DW / W;
        for (genvar l = 0; l < N; l++) begin : g_lane
            logic [W-1:0] v;
            assign v = a[l*W +: W];
            always_comb begin
                if (!shift[2])
                    cand[g][l*W +: W] = v << shift[1:0];
                else if (arith)
                    cand[g][l*W +: W] = W'($signed(v) >>> shift[1:0]);
                else
                    cand[g][l*W +: W] = v >> shift[1:0];
            end
        end
    end

    always_comb begin
        case (lane)
            LANE_8:  a_shifted = cand[0];
            LANE_16: a_shifted = cand[1];
            default: a_shifted = cand[2];
        endcase
    end
endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
    import simd_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    input  lane_e           lane,
    input  logic            lane_cin,
    output logic [DW-1:0]   sum,
    output logic [DW/8-1:0] cout
);
    localparam int SLICES = DW / 8;

    logic [SLICES-1:0] start;
    logic [8:0]        part;
    logic              carry;

    always_comb begin
        for (int i = 0; i < SLICES; i++) begin
            case (lane)
                LANE_8:  start[i] = 1'b1;
                LANE_16: start[i] = (i % 2) == 0;
                default: start[i] = (i % 4) == 0;
            endcase
        end
    end

    always_comb begin
        carry = 1'b0;
        part  = '0;
        sum   = '0;
        cout  = '0;
        for (int i = 0; i < SLICES; i++) begin
            if (start[i]) carry = lane_cin;
            part          = {1'b0, x[i*8 +: 8]} + {1'b0, y[i*8 +: 8]} + {8'd0, carry};
            sum[i*8 +: 8] = part[7:0];
            cout[i]       = part[8];
            carry         = part[8];
        end
    end
endmodule

// File: rtl/simd_lane_fix.sv
module simd_lane_fix
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         x_msb,
    input  logic         y_msb,
    input  op_e          op,
    input  pol_e         pol,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] UMAX = {W{1'b1}};

    logic top_bit;
    logic s_ovf;

    always_comb begin
        top_bit = (pol == POL_SSAT) ? (x_msb ^ y_msb ^ cout) : cout;
        s_ovf   = (x_msb == y_msb) && (sum[W-1] != x_msb);
        res     = sum;
        if (op == OP_AVG) begin
            res = {top_bit, sum[W-1:1]};
        end else if (pol == POL_SSAT) begin
            if (s_ovf) res = x_msb ? SMIN : SMAX;
        end else if (pol == POL_USAT) begin
            if (op == OP_SUB) begin
                if (!cout) res = '0;
            end else if (cout) begin
                res = UMAX;
            end
        end
    end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        sat_sel,
    input  logic [2:0]        shift_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int SLICES = DATA_W / 8;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
    } state_t;

    state_t st_d, st_q;

    lane_e lane;
    op_e   op;
    pol_e  pol;

    logic [DATA_W-1:0] a_sh, x, y, sum;
    logic [SLICES-1:0] cout;
    logic              lane_cin;
    logic [DATA_W-1:0] cand [LANE_KINDS];
    logic [DATA_W-1:0] lane_res;

    assign lane = lane_e'(lane_sel);
    assign op   = op_e'(op_sel);
    assign pol  = pol_e'(sat_sel);

    simd_preshift #(.DW(DATA_W)) u_shift (
        .a         (opnd_a),
        .lane      (lane),
        .shift     (shift_sel),
        .arith     (pol == POL_SSAT),
        .a_shifted (a_sh)
    );

    assign x        = (op == OP_SHADD) ? a_sh : opnd_a;
    assign y        = (op == OP_SUB) ? ~opnd_b : opnd_b;
    assign lane_cin = (op == OP_SUB) || (op == OP_AVG);

    simd_part_adder #(.DW(DATA_W)) u_add (
        .x        (x),
        .y        (y),
        .lane     (lane),
        .lane_cin (lane_cin),
        .sum      (sum),
        .cout     (cout)
    );

    for (genvar g = 0; g < LANE_KINDS; g++) begin : g_size
        localparam int W = 8 << g;
        localparam int N = DATA_W / W;
        for (genvar l = 0; l < N; l++) begin : g_lane
            simd_lane_fix #(.W(W)) u_fix (
                .sum   (sum[l*W +: W]),
                .cout  (cout[(l*W + W) / 8 - 1]),
                .x_msb (x[l*W + W - 1]),
                .y_msb (y[l*W + W - 1]),
                .op    (op),
                .pol   (pol),
                .res   (cand[g][l*W +: W])
            );
        end
    end

    always_comb begin
        case (lane)
            LANE_8:  lane_res = cand[0];
            LANE_16: lane_res = cand[1];
            default: lane_res = cand[2];
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.result = lane_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [1:0]        lane_sel,
    input logic [1:0]        op_sel,
    input logic [1:0]        sat_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    assert_usat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'd0 && op_sel == 2'd0 && sat_sel == 2'd2 && opnd_a[7:0] == 8'hFF)
        |=> out_result[7:0] == 8'hFF);

    assert_usat_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'd0 && op_sel == 2'd1 && sat_sel == 2'd2 && opnd_a[7:0] == 8'h00)
        |=> out_result[7:0] == 8'h00);

    assert_avg_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2 && opnd_a == opnd_b) |=> out_result == $past(opnd_a));

    assert_sub_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1 && opnd_a == opnd_b) |=> out_result == '0);
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .lane_sel   (lane_sel),
    .op_sel     (op_sel),
    .sat_sel    (sat_sel),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tb_simd_sat_alu.sv
module tb_simd_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [1:0]  lane_sel = '0, op_sel = '0, sat_sel = '0;
    logic [2:0]  shift_sel = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    simd_sat_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .lane_sel(lane_sel),
        .op_sel(op_sel), .sat_sel(sat_sel), .shift_sel(shift_sel),
        .out_valid(out_valid), .out_result(out_result)
    );

    logic [63:0] pats [8];
    initial begin
        pats[0] = 64'h0000_0000_0000_0000;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h7F7F_7F7F_7F7F_7F7F;
        pats[3] = 64'h8080_8080_8080_8080;
        pats[4] = 64'h0101_0101_0101_0101;
        pats[5] = 64'h0123_4567_89AB_CDEF;
        pats[6] = 64'h8000_7FFF_0080_FF7F;
        pats[7] = 64'h7FFF_FFFF_8000_0000;
    end

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input int lsz, input int op, input int pol,
                                          input int sh);
        int     w;
        longint mask, smax, smin, ua, ub, av, bv, r, t;
        logic [63:0] res;
        int     k;
        bit     sgn;
        w    = (lsz == 0) ? 8 : (lsz == 1) ? 16 : 32;
        mask = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -(longint'(1) << (w - 1));
        sgn  = (pol == 1);
        k    = sh & 3;
        res  = '0;
        for (int l = 0; l < 64 / w; l++) begin
            ua = longint'(a >> (l * w)) & mask;
            ub = longint'(b >> (l * w)) & mask;
            av = (sgn && ua > smax) ? ua - (mask + 1) : ua;
            bv = (sgn && ub > smax) ? ub - (mask + 1) : ub;
            case (op)
                0: r = av + bv;
                1: r = av - bv;
                2: r = (av + bv + 1) >>> 1;
                default: begin
                    if ((sh & 4) != 0) begin
                        r = (av >>> k) + bv;
                    end else begin
                        t = (av << k) & mask;
                        if (sgn && t > smax) t = t - (mask + 1);
                        r = t + bv;
                    end
                end
            endcase
            if (op != 2) begin
                if (pol == 1) begin
                    if (r > smax) r = smax;
                    if (r < smin) r = smin;
                end else if (pol == 2) begin
                    if (r > mask) r = mask;
                    if (r < 0) r = 0;
                end
            end
            res = res | (64'(r & mask) << (l * w));
        end
        return res;
    endfunction

    function automatic string tag_of(input int op, input int pol);
        string s;
        case (op)
            0: s = "R2";
            1: s = "R5";
            2: s = "R6";
            default: s = "R7";
        endcase
        if (op != 2 && pol == 1) s = {s, "/R3"};
        if (op != 2 && pol == 2) s = {s, "/R4"};
        return {s, "/R1"};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [63:0] a, input logic [63:0] b, input int lsz,
                           input int op, input int pol, input int sh,
                           input logic [63:0] exp, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        opnd_a    = a;
        opnd_b    = b;
        lane_sel  = 2'(lsz);
        op_sel    = 2'(op);
        sat_sel   = 2'(pol);
        shift_sel = 3'(sh);
        @(negedge clk);
        check(out_valid === 1'b1, {req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(out_result === exp, req, out_result, exp);
    endtask

    task automatic idle_hold(input logic [63:0] held);
        in_valid = 1'b0;
        opnd_a   = ~opnd_a;
        opnd_b   = opnd_b ^ 64'h5A5A_5A5A_5A5A_5A5A;
        @(negedge clk);
        check(out_valid === 1'b0, "R8 valid drop", {63'd0, out_valid}, 64'd0);
        check(out_result === held, "R8 hold", out_result, held);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] e, s1, s2;
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0, "R9 reset valid", {63'd0, out_valid}, 64'd0);
        check(out_result === 64'd0, "R9 reset result", out_result, 64'd0);
        rst_n = 1'b1;

        // R1: carries stopped at each lane edge
        run_one(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 0, 0, 0,
                64'h0000_0000_0000_0000, "R1 byte isolation");
        run_one(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1, 0, 0, 0,
                64'h0100_0100_0100_0100, "R1 half carry");
        run_one(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2, 1, 0, 0,
                64'hFFFF_FFFF_FFFF_FFFF, "R1 word borrow");
        // R3 16-bit clamp values
        run_one(64'h7FFF_8000_0001_FFFF, 64'h0001_FFFF_0001_FFFF, 1, 0, 1, 0,
                64'h7FFF_8000_0002_FFFE, "R3 half clamp");
        // R4 non-associative sequence under unsigned saturation
        s1 = 64'h1414_1414_1414_1414;
        run_one(64'd0, s1, 0, 0, 2, 0, s1, "R4 0+20");
        s2 = 64'd0;
        run_one(64'd0, s1, 0, 1, 2, 0, s2, "R4 0-20");
        run_one(s1, s2, 0, 0, 2, 0, s1, "R4 sum of clamped");
        idle_hold(s1);

        for (int lsz = 0; lsz < 4; lsz++)
            for (int op = 0; op < 4; op++)
                for (int pol = 0; pol < 4; pol++)
                    for (int sh = 0; sh < 8; sh++) begin
                        if (op != 3 && sh != 0) continue;
                        e = '0;
                        for (int i = 0; i < 8; i++)
                            for (int j = 0; j < 8; j++) begin
                                e = model(pats[i], pats[j], lsz, op, pol, sh);
                                run_one(pats[i], pats[j], lsz, op, pol, sh, e,
                                        tag_of(op, pol));
                            end
                        idle_hold(e);
                    end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule